// File: doc/BRIEF.md
# Interrupt Flag Controller

This block gathers interrupt requests for a small 8-bit microcontroller core. It watches three sources: an external pin whose active edge is programmable, a one-cycle overflow pulse from an 8-bit timer, and any level change on a 4-bit group of input port lines. Each source owns a sticky pending flag and a per-source enable. A global enable gates the vector request. The core sees one request line for branching to the interrupt vector and one wake line for leaving sleep.

The core reaches the block through a small register window. A control register holds the global enable (bit 7), the edge polarity (bit 6) and the per-source enables (bit 0 external, bit 1 timer, bit 2 port). A flag register holds the pending flags in the same bit order. A port register returns the synchronized port lines in bits 3:0, and reading it refreshes the reference copy used for change detection. When the core takes the vector it pulses `vec_take_i`, which clears the global enable so that requests do not nest. Flags are only ever cleared by software.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, the control register (address 0) reads 0x00, the flag register (address 1) reads 0x00, and `irq_o` and `wake_o` are low.
- R2: With the polarity bit (control bit 6) set, a rising edge on `ext_pin_i` sets flag bit 0 within four clock cycles, and a falling edge does not set it.
- R3: With the polarity bit clear, a falling edge on `ext_pin_i` sets flag bit 0 within four clock cycles, and a rising edge does not set it.
- R4: A one-cycle high on `tmr_ovf_i` sets flag bit 1 at the next clock edge.
- R5: While the synchronized `port_hi_i` differs from the reference copy, flag bit 2 is set on every cycle, so a clearing write does not remove it. A read of address 2 (with `reg_rd_i` high) returns the synchronized port in bits 3:0 and loads the reference copy. After that, a clearing write removes the flag.
- R6: A flag stays set until a write to address 1 with a zero in its bit position. Idle cycles and `vec_take_i` leave it set.
- R7: `irq_o` is high exactly when the global enable (control bit 7) is set and some flag has its enable bit set. A flag whose enable is clear raises no request.
- R8: `vec_take_i` clears the global enable at the next clock edge. This holds even when a control write in the same cycle sets it.
- R9: `wake_o` is high exactly when `sleep_i` is high and some flag has its enable set, whatever the global enable is.
- R10: When a write clears a flag in the same cycle as a new event for that source, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| ext_pin_i | input | 1 | External interrupt pin, asynchronous |
| port_hi_i | input | 4 | Watched port lines, asynchronous |
| tmr_ovf_i | input | 1 | Timer wrap pulse, one cycle, synchronous |
| sleep_i | input | 1 | Core is in sleep |
| vec_take_i | input | 1 | Core branches to the interrupt vector this cycle |
| reg_addr_i | input | 2 | Register select: 0 control, 1 flags, 2 port |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe; on address 2 it loads the port reference copy |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected register |
| irq_o | output | 1 | Request to branch to the interrupt vector |
| wake_o | output | 1 | Wake request to a sleeping core |

## Verification
The hardest case to reach from the ports is a flag clear that lands in the same cycle as a fresh event. The bench lines this up for the timer source by raising the overflow pulse in exactly the cycle that carries the clearing write. For the port source it clears the flag while a mismatch with the stale reference copy is still pending. In that case the flag has to survive until a port read has refreshed the copy. The external edge is checked in both directions under both polarities, so an edge of the wrong direction must leave the flag unset.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;

  localparam int unsigned NSRC     = 3;
  localparam int unsigned SRC_EXT  = 0;
  localparam int unsigned SRC_TMR  = 1;
  localparam int unsigned SRC_PORT = 2;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_FLAG = 2'd1,
    RA_PORT = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W      = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d[0] = d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_chain
    always_comb begin
      stg_d[s] = stg_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/irq_detect.sv
module irq_detect #(
  parameter int unsigned PORT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_s_i,
  input  logic              pol_i,
  input  logic [PORT_W-1:0] port_s_i,
  input  logic              port_load_i,
  output logic              ext_evt_o,
  output logic              port_evt_o
);

  logic              ext_prev_q;
  logic [PORT_W-1:0] port_ref_q;
  logic [PORT_W-1:0] port_ref_d;

  always_comb begin
    port_ref_d = port_ref_q;
    if (port_load_i) port_ref_d = port_s_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_prev_q <= 1'b0;
      port_ref_q <= '0;
    end else begin
      ext_prev_q <= ext_s_i;
      port_ref_q <= port_ref_d;
    end
  end

  always_comb begin
    if (pol_i) ext_evt_o = ext_s_i & ~ext_prev_q;
    else       ext_evt_o = ~ext_s_i & ext_prev_q;
    port_evt_o = |(port_s_i ^ port_ref_q);
  end

endmodule

// File: rtl/irq_flags.sv
module irq_flags #(
  parameter int unsigned NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic            wr_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] flag_o
);

  logic [NSRC-1:0] flag_q;
  logic [NSRC-1:0] flag_d;

  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    always_comb begin
      flag_d[i] = flag_q[i];
      if (wr_i)     flag_d[i] = wdata_i[i];
      if (evt_i[i]) flag_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg #(
  parameter int unsigned NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic            gie_wd_i,
  input  logic            pol_wd_i,
  input  logic [NSRC-1:0] en_wd_i,
  input  logic            vec_take_i,
  output logic            gie_o,
  output logic            pol_o,
  output logic [NSRC-1:0] en_o
);

  logic            gie_q, gie_d;
  logic            pol_q, pol_d;
  logic [NSRC-1:0] en_q,  en_d;

  always_comb begin
    gie_d = gie_q;
    pol_d = pol_q;
    en_d  = en_q;
    if (wr_i) begin
      gie_d = gie_wd_i;
      pol_d = pol_wd_i;
      en_d  = en_wd_i;
    end
    if (vec_take_i) gie_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q <= 1'b0;
      pol_q <= 1'b0;
      en_q  <= '0;
    end else begin
      gie_q <= gie_d;
      pol_q <= pol_d;
      en_q  <= en_d;
    end
  end

  assign gie_o = gie_q;
  assign pol_o = pol_q;
  assign en_o  = en_q;

endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_flag_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned PORT_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_pin_i,
  input  logic [PORT_W-1:0] port_hi_i,
  input  logic              tmr_ovf_i,
  input  logic              sleep_i,
  input  logic              vec_take_i,
  input  logic [1:0]        reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              wake_o
);

  localparam int unsigned SYNC_W  = PORT_W + 1;
  localparam int unsigned GIE_BIT = DATA_W - 1;
  localparam int unsigned POL_BIT = DATA_W - 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // input synchronization
  logic [SYNC_W-1:0] sync_out;
  logic              ext_s;
  logic [PORT_W-1:0] port_s;

  irq_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   ({port_hi_i, ext_pin_i}),
    .q_o   (sync_out)
  );
  assign ext_s  = sync_out[0];
  assign port_s = sync_out[SYNC_W-1:1];

  // register decode
  logic wr_ctrl, wr_flag, rd_port;
  assign wr_ctrl = reg_wr_i && (reg_addr_i == RA_CTRL);
  assign wr_flag = reg_wr_i && (reg_addr_i == RA_FLAG);
  assign rd_port = reg_rd_i && (reg_addr_i == RA_PORT);

  // control register
  logic            gie_q, pol_q;
  logic [NSRC-1:0] en_q;

  irq_ctrl_reg #(.NSRC(NSRC)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_i       (wr_ctrl),
    .gie_wd_i   (reg_wdata_i[GIE_BIT]),
    .pol_wd_i   (reg_wdata_i[POL_BIT]),
    .en_wd_i    (reg_wdata_i[NSRC-1:0]),
    .vec_take_i (vec_take_i),
    .gie_o      (gie_q),
    .pol_o      (pol_q),
    .en_o       (en_q)
  );

  // event detection
  logic ext_evt, port_evt;

  irq_detect #(.PORT_W(PORT_W)) u_det (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .ext_s_i     (ext_s),
    .pol_i       (pol_q),
    .port_s_i    (port_s),
    .port_load_i (rd_port),
    .ext_evt_o   (ext_evt),
    .port_evt_o  (port_evt)
  );

  // sticky flags
  logic [NSRC-1:0] evt;
  logic [NSRC-1:0] flag_q;

  always_comb begin
    evt           = '0;
    evt[SRC_EXT]  = ext_evt;
    evt[SRC_TMR]  = tmr_ovf_i;
    evt[SRC_PORT] = port_evt;
  end

  irq_flags #(.NSRC(NSRC)) u_flags (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .evt_i   (evt),
    .wr_i    (wr_flag),
    .wdata_i (reg_wdata_i[NSRC-1:0]),
    .flag_o  (flag_q)
  );

  // request outputs
  logic pending;
  assign pending = |(flag_q & en_q);
  assign irq_o   = gie_q & pending;
  assign wake_o  = sleep_i & pending;

  // read mux
  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      RA_CTRL: begin
        reg_rdata_o[GIE_BIT]    = gie_q;
        reg_rdata_o[POL_BIT]    = pol_q;
        reg_rdata_o[NSRC-1:0]   = en_q;
      end
      RA_FLAG: reg_rdata_o[NSRC-1:0]   = flag_q;
      RA_PORT: reg_rdata_o[PORT_W-1:0] = port_s;
      default: reg_rdata_o = '0;
    endcase
  end

  logic unused_wdata_bits;
  assign unused_wdata_bits = ^reg_wdata_i[POL_BIT-1:NSRC];

endmodule

// File: rtl/irq_flag_chk.sv
module irq_flag_chk
  import irq_flag_pkg::*;
(
  input logic            clk,
  input logic            rst_sync_n,
  input logic            tmr_ovf_i,
  input logic            vec_take_i,
  input logic            sleep_i,
  input logic            reg_wr_i,
  input logic [1:0]      reg_addr_i,
  input logic            irq_o,
  input logic            wake_o,
  input logic            gie_q,
  input logic [NSRC-1:0] en_q,
  input logic [NSRC-1:0] flag_q
);

  AST_WAKE_NEEDS_SLEEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wake_o |-> sleep_i);  // R9

  AST_WAKE_ON_PENDING: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sleep_i && |(flag_q & en_q)) |-> wake_o);  // R9

  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_o |-> gie_q);  // R7

  AST_VEC_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    vec_take_i |=> !gie_q);  // R8

  AST_TMR_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tmr_ovf_i |=> flag_q[SRC_TMR]);  // R4 R10

  for (genvar i = 0; i < NSRC; i++) begin : g_sticky
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (flag_q[i] && !(reg_wr_i && reg_addr_i == RA_FLAG)) |=> flag_q[i]);  // R6
  end

endmodule

bind irq_flag_ctrl irq_flag_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .tmr_ovf_i  (tmr_ovf_i),
  .vec_take_i (vec_take_i),
  .sleep_i    (sleep_i),
  .reg_wr_i   (reg_wr_i),
  .reg_addr_i (reg_addr_i),
  .irq_o      (irq_o),
  .wake_o     (wake_o),
  .gie_q      (gie_q),
  .en_q       (en_q),
  .flag_q     (flag_q)
);

// File: tb/tb_irq_flag_ctrl.sv
`timescale 1ns/1ps
module tb_irq_flag_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ext_pin;
  logic [3:0] port_hi;
  logic       tmr_ovf, sleep, vec_take;
  logic [1:0] reg_addr;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_wdata, reg_rdata;
  logic       irq, wake;

  always #2 clk = ~clk;  // 250 MHz

  irq_flag_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ext_pin_i(ext_pin), .port_hi_i(port_hi),
    .tmr_ovf_i(tmr_ovf), .sleep_i(sleep), .vec_take_i(vec_take),
    .reg_addr_i(reg_addr), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_o(irq), .wake_o(wake)
  );

  typedef struct {
    string      req;
    bit         out_sel;  // 0: read data, 1: {wake, irq}
    logic [7:0] exp;
  } item_t;

  item_t q[$];
  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // monitor: pops expected items and compares away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        logic [7:0] got;
        it = q.pop_front();
        got = it.out_sel ? {6'b0, wake, irq} : reg_rdata;
        compared++;
        if (got !== it.exp) begin
          mismatched++;
          $display("FAIL %s: got 0x%02h expected 0x%02h", it.req, got, it.exp);
        end
      end
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic exp_reg(string req, logic [1:0] a, logic [7:0] e);
    item_t it;
    reg_addr = a;
    it.req = req; it.out_sel = 1'b0; it.exp = e;
    q.push_back(it);
    step();
  endtask

  task automatic exp_out(string req, logic [7:0] e);
    item_t it;
    it.req = req; it.out_sel = 1'b1; it.exp = e;
    q.push_back(it);
    step();
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic tmr_pulse();
    tmr_ovf = 1'b1;
    step();
    tmr_ovf = 1'b0;
  endtask

  task automatic vec_pulse();
    vec_take = 1'b1;
    step();
    vec_take = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; ext_pin = 1'b0; port_hi = 4'h0; tmr_ovf = 1'b0;
    sleep = 1'b0; vec_take = 1'b0; reg_addr = 2'd0; reg_wr = 1'b0;
    reg_rd = 1'b0; reg_wdata = 8'h00;
    step(4);
    rst_n = 1'b1;
    step(4);

    // R1 reset state
    exp_reg("R1 ctrl", 2'd0, 8'h00);
    exp_reg("R1 flags", 2'd1, 8'h00);
    exp_out("R1 irq/wake", 8'h00);

    // R3 falling edge with polarity clear
    wr(2'd0, 8'h00);
    ext_pin = 1'b1; step(4);
    exp_reg("R3 rising ignored", 2'd1, 8'h00);
    ext_pin = 1'b0; step(4);
    exp_reg("R3 falling sets", 2'd1, 8'h01);
    wr(2'd1, 8'h00);
    exp_reg("R6 clear by write", 2'd1, 8'h00);

    // R2 rising edge with polarity set
    wr(2'd0, 8'h40);
    ext_pin = 1'b1; step(4);
    exp_reg("R2 rising sets", 2'd1, 8'h01);
    wr(2'd1, 8'h00);
    ext_pin = 1'b0; step(4);
    exp_reg("R2 falling ignored", 2'd1, 8'h00);

    // R4 timer overflow
    tmr_pulse();
    exp_reg("R4 tmr sets", 2'd1, 8'h02);

    // R6 sticky across idle and vector entry
    step(10);
    exp_reg("R6 idle keeps", 2'd1, 8'h02);
    vec_pulse();
    exp_reg("R6 vector keeps", 2'd1, 8'h02);

    // R7 request gating
    wr(2'd0, 8'h42);
    exp_out("R7 no gie", 8'h00);
    wr(2'd0, 8'hC2);
    exp_out("R7 gie+en", 8'h01);
    wr(2'd0, 8'hC1);
    exp_out("R7 en clear blocks", 8'h00);

    // R8 vector clears global enable, wins over write
    wr(2'd0, 8'hC2);
    vec_pulse();
    exp_reg("R8 gie cleared", 2'd0, 8'h42);
    exp_out("R8 irq dropped", 8'h00);
    reg_addr = 2'd0; reg_wdata = 8'hC2; reg_wr = 1'b1; vec_take = 1'b1;
    step();
    reg_wr = 1'b0; vec_take = 1'b0;
    exp_reg("R8 vector beats write", 2'd0, 8'h42);

    // R9 wake without global enable
    wr(2'd0, 8'h02);
    sleep = 1'b1; step();
    exp_out("R9 wake", 8'h02);
    wr(2'd0, 8'h00);
    exp_out("R9 no enable no wake", 8'h00);
    sleep = 1'b0;
    wr(2'd0, 8'h02);
    exp_out("R9 awake no wake", 8'h00);

    // R10 clear collides with new event
    reg_addr = 2'd1; reg_wdata = 8'h00; reg_wr = 1'b1; tmr_ovf = 1'b1;
    step();
    reg_wr = 1'b0; tmr_ovf = 1'b0;
    exp_reg("R10 event wins", 2'd1, 8'h02);
    wr(2'd1, 8'h00);
    exp_reg("R10 later clear", 2'd1, 8'h00);

    // R5 port change
    port_hi = 4'h5; step(4);
    exp_reg("R5 change sets", 2'd1, 8'h04);
    wr(2'd1, 8'h00);
    exp_reg("R5 mismatch persists", 2'd1, 8'h04);
    reg_addr = 2'd2; reg_rd = 1'b1;
    step();
    reg_rd = 1'b0;
    exp_reg("R5 port readback", 2'd2, 8'h05);
    wr(2'd1, 8'h00);
    step(3);
    exp_reg("R5 cleared after read", 2'd1, 8'h00);
    port_hi = 4'h4; step(4);
    exp_reg("R5 second change", 2'd1, 8'h04);

    step(2);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule